// File: doc/BRIEF.md
# Rotating-Token Fair Arbiter

This block shares one resource among a set of requesters (four by default) without letting any of them starve. A one-hot token circulates around a ring, moving one place on every enabled clock cycle. Each token position turns on its own priority encoder, and each encoder is rotated so that the requester sitting at that token position comes first. The other requesters follow it in circular order. If the token holder is not asking, the next asking requester in that circular order wins.

The winner is captured in a register, so the decision appears one cycle after the request lines are sampled. Each cycle's decision is independent of the last one. The result appears on two outputs:
- a one-hot grant vector;
- the binary number of the granted requester.

When the enable input is low, no grant is issued and the token stays where it is. A synchronous active-high reset puts the token at position 0 and clears both outputs.

Top module: `fair_token_arbiter`

## Requirements
- R1: While `rst` is sampled high at a clock edge, `grant` and `grant_idx` are all-zero after that edge, and the token returns to position 0. The first enabled cycle after reset, with every request line high, therefore grants requester 0 (`grant` = 4'b0001).
- R2: The token advances one position, from p to (p+1) mod N, on every clock edge at which `en` is high. With every request line held high, the grants visit requesters 0, 1, 2, 3, 0 and so on, one per cycle.
- R3: If `en` is high and the token holder's request line is high at an edge, that requester is granted after the edge.
- R4: If `en` is high and the token holder at position p is not requesting, the grant goes to the first requesting line among p+1, p+2, … taken mod N.
- R5: At most one bit of `grant` is ever high. A bit of `grant` is high only if that request line was high at the edge that loaded it.
- R6: If `en` is high and no request line is high at an edge, `grant` and `grant_idx` are zero after that edge.
- R7: If `en` is low at an edge, `grant` and `grant_idx` are zero after that edge and the token does not move. The first enabled cycle afterwards resolves from the held token position.
- R8: `grant_idx` is the bit position of the single high bit of `grant`, updated in the same cycle as `grant`. It is zero when `grant` is zero.
- R9: A requester whose line stays high through enabled cycles is granted at least once in every N consecutive such cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Arbitration enable; low freezes the token and suppresses grants |
| req | input | NUM_REQ (4) | Request lines, bit i from requester i |
| grant | output | NUM_REQ (4) | Registered one-hot grant, bit i to requester i |
| grant_idx | output | IDX_W (2) | Registered binary number of the granted requester |

## Verification
The assertions expect the request lines and the enable to be stable around each rising edge. They also expect reset to be held for at least one edge before arbitration starts. The bench meets both conditions by changing `req`, `en` and `rst` only on falling edges. The enable-low and reset cases are entered from the middle of a token rotation, so the held token position and the restart at position 0 are checked by the grants that follow.

// File: rtl/arb_pkg.sv
package arb_pkg;
  function automatic int wrap_idx(input int v, input int n);
    return v % n;
  endfunction
endpackage

// File: rtl/arb_token_ring.sv
module arb_token_ring #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  output logic [N-1:0] tok
);
  logic [N-1:0] tok_q;

  always_ff @(posedge clk) begin
    if (rst)     tok_q <= {{(N-1){1'b0}}, 1'b1};
    else if (en) tok_q <= {tok_q[N-2:0], tok_q[N-1]};
  end

  assign tok = tok_q;

  p_tok_onehot_r2: assert property (@(posedge clk) disable iff (rst) $onehot(tok_q));
  p_tok_hold_r7:   assert property (@(posedge clk) disable iff (rst) !en |=> $stable(tok_q));
endmodule

// File: rtl/arb_rot_prio.sv
module arb_rot_prio #(
  parameter int N      = 4,
  parameter int OFFSET = 0
) (
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    logic found;
    gnt_o = '0;
    found = 1'b0;
    for (int k = 0; k < N; k++) begin
      if (en_i && !found && req_i[arb_pkg::wrap_idx(OFFSET + k, N)]) begin
        gnt_o[arb_pkg::wrap_idx(OFFSET + k, N)] = 1'b1;
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_grant_out.sv
module arb_grant_out #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic [N-1:0]          req,
  input  logic [N-1:0][N-1:0]   blk_gnt,
  output logic [N-1:0]          grant,
  output logic [IDX_W-1:0]      grant_idx
);
  logic [N-1:0]     merged;
  logic [IDX_W-1:0] enc;
  logic [N-1:0]     grant_q;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    merged = '0;
    for (int b = 0; b < N; b++) merged = merged | blk_gnt[b];
  end

  always_comb begin
    enc = '0;
    for (int i = 0; i < N; i++)
      if (merged[i]) enc = enc | IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      grant_q <= '0;
      idx_q   <= '0;
    end else begin
      grant_q <= merged;
      idx_q   <= enc;
    end
  end

  assign grant     = grant_q;
  assign grant_idx = idx_q;

  p_grant_onehot_r5: assert property (@(posedge clk) disable iff (rst) $onehot0(grant_q));
  p_grant_req_r5:    assert property (@(posedge clk) disable iff (rst)
                       (|grant_q) |-> ((grant_q & $past(req)) != '0));
  p_idle_r6:         assert property (@(posedge clk) disable iff (rst)
                       (req == '0) |=> (grant_q == '0));
  p_idx_r8:          assert property (@(posedge clk) disable iff (rst)
                       (|grant_q) |-> grant_q[idx_q]);
  p_idx_zero_r8:     assert property (@(posedge clk) disable iff (rst)
                       (grant_q == '0) |-> (idx_q == '0));
endmodule

// File: rtl/fair_token_arbiter.sv
module fair_token_arbiter #(
  parameter int NUM_REQ = 4,
  localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [NUM_REQ-1:0] req,
  output logic [NUM_REQ-1:0] grant,
  output logic [IDX_W-1:0]   grant_idx
);
  logic [NUM_REQ-1:0]              tok;
  logic [NUM_REQ-1:0][NUM_REQ-1:0] blk_gnt;

  arb_token_ring #(.N(NUM_REQ)) u_ring (
    .clk(clk), .rst(rst), .en(en), .tok(tok)
  );

  for (genvar b = 0; b < NUM_REQ; b++) begin : g_blk
    arb_rot_prio #(.N(NUM_REQ), .OFFSET(b)) u_prio (
      .en_i(tok[b]), .req_i(req), .gnt_o(blk_gnt[b])
    );
  end

  arb_grant_out #(.N(NUM_REQ), .IDX_W(IDX_W)) u_out (
    .clk(clk), .rst(rst), .en(en), .req(req), .blk_gnt(blk_gnt),
    .grant(grant), .grant_idx(grant_idx)
  );

  p_holder_r3: assert property (@(posedge clk) disable iff (rst)
                 (en && ((req & tok) != '0)) |=> (grant == $past(tok)));
  p_en_off_r7: assert property (@(posedge clk) disable iff (rst)
                 !en |=> (grant == '0));
endmodule

// File: tb/fair_token_arbiter_tb.sv
module fair_token_arbiter_tb;
  logic       clk = 0;
  logic       rst = 1;
  logic       en  = 0;
  logic [3:0] req = '0;
  logic [3:0] grant;
  logic [1:0] grant_idx;

  int total = 0, bad = 0;
  int mtok = 0;
  logic [3:0] mexp = '0;
  int since1 = 0;

  always #2 clk = ~clk;

  fair_token_arbiter #(.NUM_REQ(4)) u_dut (
    .clk(clk), .rst(rst), .en(en), .req(req), .grant(grant), .grant_idx(grant_idx)
  );

  always @(posedge clk) begin
    if (rst) begin
      mtok = 0; mexp = '0;
    end else if (!en) begin
      mexp = '0;
    end else begin
      mexp = '0;
      for (int k = 0; k < 4; k++) begin
        if (mexp == '0 && req[(mtok + k) % 4]) mexp[(mtok + k) % 4] = 1'b1;
      end
      mtok = (mtok + 1) % 4;
    end
  end

  function automatic int enc(input logic [3:0] g);
    for (int i = 0; i < 4; i++) if (g[i]) return i;
    return 0;
  endfunction

  task automatic cyc(input logic r, input logic e, input logic [3:0] rq, input string tag);
    rst = r; en = e; req = rq;
    @(negedge clk);
    total++;
    if (grant !== mexp) begin
      bad++;
      $display("FAIL %s grant act=%b exp=%b", tag, grant, mexp);
    end
    total++;
    if (grant_idx !== 2'(enc(mexp))) begin
      bad++;
      $display("FAIL R8 %s idx act=%0d exp=%0d", tag, grant_idx, enc(mexp));
    end
  endtask

  task automatic lit(input logic [3:0] exp, input string tag);
    total++;
    if (grant !== exp) begin
      bad++;
      $display("FAIL %s literal act=%b exp=%b", tag, grant, exp);
    end
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc(1, 0, 4'b1111, "R1 reset");
    lit(4'b0000, "R1");
    cyc(0, 1, 4'b1111, "R1 first");
    lit(4'b0001, "R1");
    cyc(0, 1, 4'b1111, "R2 step1"); lit(4'b0010, "R2");
    cyc(0, 1, 4'b1111, "R2 step2"); lit(4'b0100, "R2");
    cyc(0, 1, 4'b1111, "R2 step3"); lit(4'b1000, "R2");
    cyc(0, 1, 4'b1111, "R2 wrap");  lit(4'b0001, "R2");
    // token now at 1
    cyc(0, 1, 4'b0010, "R3 holder"); lit(4'b0010, "R3");
    // token at 2; holder absent, 3 absent, 0 wins
    cyc(0, 1, 4'b0011, "R4 skip");   lit(4'b0001, "R4");
    // token at 3; only 2 requests: 3,0,1 skipped
    cyc(0, 1, 4'b0100, "R4 far");    lit(4'b0100, "R4");
    // token at 0
    cyc(0, 1, 4'b0000, "R6 none");   lit(4'b0000, "R6");
    // token at 1; freeze
    cyc(0, 0, 4'b1111, "R7 off");    lit(4'b0000, "R7");
    cyc(0, 0, 4'b1111, "R7 off2");   lit(4'b0000, "R7");
    cyc(0, 1, 4'b1111, "R7 resume"); lit(4'b0010, "R7");
    // mid-rotation reset
    cyc(0, 1, 4'b1111, "R2 pre");
    cyc(1, 1, 4'b1111, "R1 midreset"); lit(4'b0000, "R1");
    cyc(0, 1, 4'b1111, "R1 restart"); lit(4'b0001, "R1");
    // random patterns with requester 1 held high
    since1 = 0;
    for (int n = 0; n < 400; n++) begin
      cyc(0, 1, 4'($urandom) | 4'b0010, "R5 R9 rand");
      if (grant[1]) since1 = 0; else since1++;
      total++;
      if (since1 >= 4) begin
        bad++;
        $display("FAIL R9 starve act=%0d exp<4", since1);
      end
    end
    for (int n = 0; n < 400; n++) begin
      cyc(0, ($urandom % 4) != 0, 4'($urandom), "R4 R7 rand");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule